// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is a slave serial port that gives an external controller read and write access to a small register file. The port has three wires: a chip-enable that frames each transaction, a serial clock, and a data line. The data line is split into an input, an output and an output enable, so that a pad can be wrapped around it. All three pins are brought into the block's own clock domain through synchronizers. The serial clock must therefore be slow compared with the system clock.

The register file holds sixteen core registers (addresses 00h to 0Fh) and five extra bytes (10h to 14h) for trim and user data. Every transaction starts with a command byte that names the address and the direction. One data byte follows, or a burst that walks through all sixteen core registers. Bytes travel least significant bit first. The controller's bits are captured on rising serial clock edges, and the block drives its bits after falling edges. Bit 7 of register 07h is a write-protect flag. It blocks writes to every other address.

Top module: `tw_serial_regs`

## Requirements
- R1: After reset, register 07h holds 80h, every other register holds 00h, and `sdio_oe_o` is low.
- R2: Command 80h + 2n (n from 0 to 20, LSB first) followed by eight data bits writes that byte to address n. Bit k of the data is captured on the k-th rising clock after the command. The register changes only once the eighth bit has been received.
- R3: While bit 7 of register 07h is 1, writes to every address other than 07h are dropped. A write to 07h is always accepted, so protection can be cleared.
- R4: Command BEh writes the next sixteen bytes to addresses 00h..0Fh in order. Write protection is judged per byte, using the flag's value at that byte's commit. Bytes after the sixteenth are ignored. Command BFh reads 00h..0Fh in order and wraps from 0Fh back to 00h.
- R5: Command 81h + 2n reads address n. Bit 0 is driven after the falling edge that follows the eighth command bit, and each later falling edge drives the next bit. `sdio_oe_o` stays low during the command and goes high at that first falling edge.
- R6: In a single-byte read, further clocks while chip-enable stays high send the same byte again.
- R7: In a single-byte write, clocks after the eighth data bit change no register.
- R8: Dropping chip-enable ends the transaction. A partially received data byte is discarded, and `sdio_oe_o` goes low.
- R9: A command whose bit 7 is 0, whose bit 6 is 1, or whose address field is 15h..1Eh is ignored until chip-enable drops. Nothing is driven and nothing is written.
- R10: Addresses 10h..14h are reached only by single-byte commands. A burst never reads or writes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip-enable; high frames a transaction |
| sclk_i | input | 1 | Serial clock from the controller |
| sdio_i | input | 1 | Serial data from the controller |
| sdio_o | output | 1 | Serial data to the controller |
| sdio_oe_o | output | 1 | Output enable for the data line; low means high impedance |

## Verification
The bound checker watches, on every cycle, four rules that do not depend on the command being sent:
- the output enable falls after chip-enable drops;
- the output enable rises and driven bits change only after a detected falling serial edge;
- the register file changes only after a completed-byte write strobe;
- a strobe aimed at a protected address leaves the file untouched.

Other behaviours can only be shown by the bench's scenarios, because they depend on the whole stream of bits:
- command decoding and the bit ordering;
- burst sequencing, wrap-around and the per-byte judgement of protection;
- repetition in single reads;
- dropping of excess and aborted bits;
- rejection of invalid commands.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W     = 8;
  localparam int CNT_W      = $clog2(BYTE_W);
  localparam int CMD_ADDR_W = 5;   // address field of the command byte
  localparam int WP_ADDR    = 7;
  localparam int WP_BIT     = 7;

  typedef enum logic [1:0] {
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_IGN
  } tw_state_e;

  function automatic logic [BYTE_W-1:0] reset_value(input int idx);
    return (idx == WP_ADDR) ? BYTE_W'(1 << WP_BIT) : '0;
  endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile
  import tw_pkg::*;
#(
  parameter int NUM_ADDR = 21
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [CMD_ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0]     wr_data_i,
  input  logic [CMD_ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0]     rd_data_o
);
  logic [NUM_ADDR-1:0][BYTE_W-1:0] regs_q;
  logic wp;
  logic wr_ok;

  assign wp    = regs_q[WP_ADDR][WP_BIT];
  assign wr_ok = wr_en_i && (wr_addr_i < CMD_ADDR_W'(NUM_ADDR)) &&
                 (!wp || wr_addr_i == CMD_ADDR_W'(WP_ADDR));

  for (genvar i = 0; i < NUM_ADDR; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[i] <= reset_value(i);
      else if (wr_ok && wr_addr_i == CMD_ADDR_W'(i)) regs_q[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_ADDR; i++)
      if (rd_addr_i == CMD_ADDR_W'(i)) rd_data_o = regs_q[i];
  end
endmodule

// File: rtl/tw_frame.sv
module tw_frame
  import tw_pkg::*;
#(
  parameter int NUM_ADDR  = 21,
  parameter int BURST_LEN = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ce_i,
  input  logic                  rise_i,
  input  logic                  fall_i,
  input  logic                  sdi_i,
  input  logic [BYTE_W-1:0]     rd_data_i,
  output logic [CMD_ADDR_W-1:0] ptr_o,
  output logic                  wr_en_o,
  output logic [CMD_ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0]     wr_data_o,
  output logic                  sdo_o,
  output logic                  sdo_oe_o
);
  localparam logic [CMD_ADDR_W-1:0] BURST_CODE = '1;
  localparam logic [CMD_ADDR_W-1:0] BURST_LAST = CMD_ADDR_W'(BURST_LEN-1);
  localparam logic [CNT_W-1:0]      CNT_LAST   = CNT_W'(BYTE_W-1);

  tw_state_e             state_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [BYTE_W-2:0]     sr_q;
  logic                  burst_q;
  logic [CMD_ADDR_W-1:0] ptr_q;

  logic [BYTE_W-1:0]     rx_byte;
  logic [CMD_ADDR_W-1:0] cmd_addr;
  logic                  cmd_burst;
  logic                  cmd_ok;

  assign rx_byte   = {sdi_i, sr_q};
  assign cmd_addr  = rx_byte[CMD_ADDR_W:1];
  assign cmd_burst = (cmd_addr == BURST_CODE);
  assign cmd_ok    = rx_byte[BYTE_W-1] && !rx_byte[BYTE_W-2] &&
                     (cmd_burst || cmd_addr < CMD_ADDR_W'(NUM_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_CMD;
      cnt_q     <= '0;
      sr_q      <= '0;
      burst_q   <= 1'b0;
      ptr_q     <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      sdo_o     <= 1'b0;
      sdo_oe_o  <= 1'b0;
    end else if (!ce_i) begin
      state_q  <= ST_CMD;
      cnt_q    <= '0;
      burst_q  <= 1'b0;
      ptr_q    <= '0;
      wr_en_o  <= 1'b0;
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      unique case (state_q)
        ST_CMD: if (rise_i) begin
          sr_q  <= rx_byte[BYTE_W-1:1];
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            if (cmd_ok) begin
              burst_q <= cmd_burst;
              ptr_q   <= cmd_burst ? '0 : cmd_addr;
              state_q <= rx_byte[0] ? ST_RD : ST_WR;
            end else begin
              state_q <= ST_IGN;
            end
          end
        end
        ST_WR: if (rise_i) begin
          sr_q  <= rx_byte[BYTE_W-1:1];
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= ptr_q;
            wr_data_o <= rx_byte;
            if (burst_q && ptr_q != BURST_LAST) ptr_q <= ptr_q + 1'b1;
            else state_q <= ST_IGN;
          end
        end
        ST_RD: if (fall_i) begin
          sdo_o    <= rd_data_i[cnt_q];
          sdo_oe_o <= 1'b1;
          cnt_q    <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST && burst_q)
            ptr_q <= (ptr_q == BURST_LAST) ? '0 : ptr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/tw_serial_regs.sv
module tw_serial_regs
  import tw_pkg::*;
#(
  parameter int NUM_CORE    = 16,
  parameter int NUM_EXTRA   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic sclk_i,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe_o
);
  localparam int NUM_ADDR = NUM_CORE + NUM_EXTRA;

  logic [2:0] pins_s;
  logic ce_s, sclk_s, sdi_s, sclk_q;
  logic sclk_rise, sclk_fall;
  logic [CMD_ADDR_W-1:0] ptr;
  logic [CMD_ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic wr_en;

  tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ce_i, sclk_i, sdio_i}),
    .q_o   (pins_s)
  );

  assign {ce_s, sclk_s, sdi_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else sclk_q <= sclk_s;
  end

  assign sclk_rise = sclk_s && !sclk_q;
  assign sclk_fall = !sclk_s && sclk_q;

  tw_frame #(.NUM_ADDR(NUM_ADDR), .BURST_LEN(NUM_CORE)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_i     (ce_s),
    .rise_i   (sclk_rise),
    .fall_i   (sclk_fall),
    .sdi_i    (sdi_s),
    .rd_data_i(rd_data),
    .ptr_o    (ptr),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .sdo_o    (sdio_o),
    .sdo_oe_o (sdio_oe_o)
  );

  tw_regfile #(.NUM_ADDR(NUM_ADDR)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(ptr),
    .rd_data_o(rd_data)
  );
endmodule

// File: rtl/tw_serial_regs_chk.sv
module tw_serial_regs_chk
  import tw_pkg::*;
#(
  parameter int NUM_ADDR = 21
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            ce_s,
  input logic                            sclk_fall,
  input logic                            sdio_o,
  input logic                            sdio_oe_o,
  input logic                            wr_en,
  input logic [CMD_ADDR_W-1:0]           wr_addr,
  input logic [NUM_ADDR-1:0][BYTE_W-1:0] regs_q
);
  logic wp;
  assign wp = regs_q[WP_ADDR][WP_BIT];

  // R8
  ce_drop_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_s |=> !sdio_oe_o);

  // R5
  oe_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdio_oe_o) |-> $past(sclk_fall));

  // R5
  data_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o && $past(sdio_oe_o) && !$stable(sdio_o) |-> $past(sclk_fall));

  // R2
  commit_by_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_q) |-> $past(wr_en));

  // R3
  protect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en && wp && wr_addr != CMD_ADDR_W'(WP_ADDR) |=> $stable(regs_q));
endmodule

bind tw_serial_regs tw_serial_regs_chk #(.NUM_ADDR(NUM_ADDR)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ce_s     (ce_s),
  .sclk_fall(sclk_fall),
  .sdio_o   (sdio_o),
  .sdio_oe_o(sdio_oe_o),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .regs_q   (u_rf.regs_q)
);

// File: tb/test_tw_serial_regs.sv
module test_tw_serial_regs;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NREG = 21;

  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] model [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_serial_regs i_tw_serial_regs (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sclk_i(sclk),
    .sdio_i(sdi), .sdio_o(sdo), .sdio_oe_o(oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] cmd_of(input int a, input bit rd);
    return 8'h80 | 8'(a << 1) | {7'd0, rd};
  endfunction

  function automatic void model_write(input int a, input logic [7:0] d);
    if (a == 7 || !model[7][7]) model[a] = d;
  endfunction

  task automatic send_bit(input logic b);
    sdi = b; tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic recv_byte(output logic [7:0] b, output logic oe_all, output logic oe_any);
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick(HALF);
      b[i] = sdo;
      oe_all &= oe; oe_any |= oe;
      sclk = 1'b1; tick(HALF); sclk = 1'b0;
    end
  endtask

  task automatic begin_x;
    ce = 1'b1; tick(HALF);
  endtask

  task automatic end_x;
    tick(HALF); ce = 1'b0; tick(2*HALF);
  endtask

  task automatic wr1(input int a, input logic [7:0] d);
    begin_x; send_byte(cmd_of(a, 1'b0)); send_byte(d); end_x;
    model_write(a, d);
  endtask

  task automatic rd1(input int a, output logic [7:0] d, output logic ok);
    logic any;
    begin_x; send_byte(cmd_of(a, 1'b1)); recv_byte(d, ok, any); end_x;
  endtask

  task automatic check_all(input string req);
    logic [7:0] d; logic ok;
    for (int a = 0; a < NREG; a++) begin
      rd1(a, d, ok);
      chk(req, d, model[a]);
      if (!ok) chk({req, " oe"}, ok, 1'b1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, bw [16];
    logic all, any;
    int a;
    void'($urandom(32'd7131));
    for (int i = 0; i < NREG; i++) model[i] = (i == 7) ? 8'h80 : 8'h00;
    tick(5); rst_n = 1'b1; tick(5);

    // R1 reset state
    chk("R1 oe after reset", oe, 1'b0);
    check_all("R1 reset values");

    // R3 protected write dropped, protect register still writable
    wr1(3, 8'h5A);
    rd1(3, d, all); chk("R3 blocked write", d, 8'h00);
    wr1(7, 8'h00);
    rd1(7, d, all); chk("R3 protect cleared", d, 8'h00);

    // R2 R10 random single writes, occasionally re-arming protection
    for (int n = 0; n < 24; n++) begin
      a = $urandom_range(0, NREG-1);
      d = 8'($urandom);
      if (a == 7) d[7] = ($urandom_range(0, 3) == 0);
      wr1(a, d);
    end
    check_all("R2 random writes");
    wr1(7, 8'h00);
    wr1(20, 8'hC3);
    wr1(16, 8'h3C);

    // R5 first bit after the fall that follows the eighth command bit
    begin_x;
    d = cmd_of(16, 1'b1);
    for (int i = 0; i < 7; i++) send_bit(d[i]);
    sdi = d[7]; tick(HALF); sclk = 1'b1; tick(HALF);
    chk("R5 oe low during command", oe, 1'b0);
    sclk = 1'b0;
    recv_byte(d, all, any);
    chk("R5 oe from first fall", all, 1'b1);
    chk("R5 read data", d, model[16]);
    // R6 repeated byte
    for (int r = 0; r < 2; r++) begin
      recv_byte(d, all, any);
      chk("R6 repeat read", d, model[16]);
    end
    end_x;

    // R4 burst write with protection off, seventeenth byte ignored
    for (int i = 0; i < 16; i++) bw[i] = 8'($urandom);
    bw[7][7] = 1'b0;
    begin_x; send_byte(8'hBE);
    for (int i = 0; i < 16; i++) begin send_byte(bw[i]); model_write(i, bw[i]); end
    send_byte(~bw[0]);
    end_x;
    // R4 R10 burst read with wrap
    begin_x; send_byte(8'hBF);
    for (int i = 0; i < 18; i++) begin
      recv_byte(d, all, any);
      chk("R4 burst read", d, model[i % 16]);
    end
    end_x;
    rd1(20, d, all); chk("R10 extra byte untouched by burst", d, 8'hC3);
    rd1(16, d, all); chk("R10 extra byte untouched by burst", d, 8'h3C);

    // R4 R3 burst with protection armed: byte 7 clears it mid-burst
    wr1(7, 8'h80);
    for (int i = 0; i < 16; i++) bw[i] = 8'($urandom);
    bw[7] = 8'h00;
    begin_x; send_byte(8'hBE);
    for (int i = 0; i < 16; i++) begin send_byte(bw[i]); model_write(i, bw[i]); end
    end_x;
    check_all("R4 per-byte protection");

    // R7 extra clocks after a single write
    wr1(2, 8'hA5);
    begin_x; send_byte(cmd_of(2, 1'b0)); send_byte(8'h69); send_byte(8'h96); end_x;
    model_write(2, 8'h69);
    rd1(2, d, all); chk("R7 extra clocks ignored", d, 8'h69);
    rd1(3, d, all); chk("R7 neighbour unchanged", d, model[3]);

    // R8 aborted write and aborted read
    begin_x; send_byte(cmd_of(4, 1'b0));
    for (int i = 0; i < 5; i++) send_bit(~model[4][i]);
    ce = 1'b0; tick(2*HALF);
    rd1(4, d, all); chk("R8 partial byte discarded", d, model[4]);
    begin_x; send_byte(cmd_of(4, 1'b1));
    for (int i = 0; i < 3; i++) begin tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0; end
    tick(2);
    chk("R8 oe high mid read", oe, 1'b1);
    ce = 1'b0; tick(HALF);
    chk("R8 oe low after ce drop", oe, 1'b0);
    tick(HALF);

    // R9 invalid commands
    begin_x; send_byte(8'h2A); send_byte(8'hFF); recv_byte(d, all, any); end_x;
    chk("R9 bit7 clear no drive", any, 1'b0);
    begin_x; send_byte(8'hC1); recv_byte(d, all, any); end_x;
    chk("R9 bit6 set no drive", any, 1'b0);
    begin_x; send_byte(8'hAB); recv_byte(d, all, any); end_x;
    chk("R9 out of range read no drive", any, 1'b0);
    begin_x; send_byte(8'hAA); send_byte(8'h11); end_x;
    begin_x; send_byte(8'h6A); send_byte(8'h11); end_x;
    check_all("R9 nothing written");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule